// File: doc/BRIEF.md
# Bordered Video Timing Generator

This block produces the raster timing for a display pipe. A pixel-clock enable advances a horizontal position counter and a line counter. From programmed interval lengths the block decodes where each axis sits in its scan. A line has six consecutive intervals: sync pulse, back porch, leading border, active picture, trailing border and front porch. A frame uses the same six intervals, counted in lines. From these intervals it drives a sync output for each axis, a picture-enable and a border-enable.

Each sync output has its own polarity control. In interlaced operation a field bit alternates from frame to frame. Because the vertical lengths count lines per field, the visible picture is twice the programmed active height. On the odd field the vertical sync pulse starts and ends half a line late. All settings pass through shadow registers that are refreshed only when a new frame begins. A write in the middle of a frame therefore never disturbs the frame being scanned.

Top module: `video_timing_gen`

## Requirements
- R1: Within a line the horizontal position walks through sync, back porch, leading border, active, trailing border, front porch. Each interval length is the field `h_lens[k*CW +: CW]`, where k counts 0 for sync through 5 for front porch. The horizontal sync interval is active while `h_pos` is below the sync length.
- R2: Within a frame the line counter walks through the same six intervals, using `v_lens` with the same field order. On an even field the vertical sync interval is active while `v_pos` is below the vertical sync length.
- R3: `h_pos` counts 0 up to the sum of the six horizontal lengths minus one and then returns to 0. `v_pos` steps by one at each return of `h_pos` and wraps after the sum of the six vertical lengths.
- R4: `disp_en` is 1 exactly when both axes are in their active interval.
- R5: `bord_en` is 1 when both axes are within leading border, active or trailing border and `disp_en` is 0.
- R6: `hsync` equals the horizontal sync interval XOR the horizontal invert setting. `vsync` equals the vertical sync interval XOR the vertical invert setting, and the two settings are independent.
- R7: An interval of length zero is skipped: the counters advance straight into the next interval, with no idle step.
- R8: The lengths, invert settings and interlace setting are captured when a new frame begins. Changes at other times have no effect on the frame in progress.
- R9: At each frame end `field` inverts if interlace was on for the finished frame; otherwise it is cleared to 0.
- R10: When `field` is 1 and the vertical sync length S is nonzero, vertical sync begins on line 0 at `h_pos` = floor(line total / 2) and ends on line S at the same position.
- R11: While `pix_en` is 0 the positions, the field and all outputs hold their values.
- R12: After reset all outputs and positions are 0. The first `pix_en` captures the settings with the positions kept at 0, and counting starts on the next `pix_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel advance enable |
| h_lens | input | 6*CW | Horizontal interval lengths, sync in the lowest field |
| v_lens | input | 6*CW | Vertical interval lengths, sync in the lowest field |
| h_inv | input | 1 | Invert horizontal sync |
| v_inv | input | 1 | Invert vertical sync |
| ilace | input | 1 | Interlace enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Active picture enable |
| bord_en | output | 1 | Border enable |
| h_pos | output | CW+3 | Horizontal position |
| v_pos | output | CW+3 | Line position |
| field | output | 1 | Current field, 1 = odd |

## Verification
The hardest case to reach is the odd-field vertical sync, whose edges fall halfway through a line. Reaching it needs interlace captured at one frame boundary and the field bit inverted at the next. The bench therefore runs every configuration for three whole frames and compares every pixel against a model that tracks shadow and pending settings separately. A further directed run changes the settings mid-frame, to show that they take effect only at the following frame start.

// File: rtl/video_timing_gen.sv
module video_timing_gen #(
  parameter int CW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_en,
  input  logic [6*CW-1:0] h_lens,
  input  logic [6*CW-1:0] v_lens,
  input  logic            h_inv,
  input  logic            v_inv,
  input  logic            ilace,
  output logic            hsync,
  output logic            vsync,
  output logic            disp_en,
  output logic            bord_en,
  output logic [CW+2:0]   h_pos,
  output logic [CW+2:0]   v_pos,
  output logic            field
);
  localparam int TW = CW + 3;

  function automatic logic [TW-1:0] upto(input logic [6*CW-1:0] l, input int n);
    logic [TW-1:0] s;
    s = '0;
    for (int k = 0; k < 6; k++)
      if (k < n) s = s + TW'(l[k*CW +: CW]);
    return s;
  endfunction

  logic [6*CW-1:0] hl_q, vl_q;
  logic            hinv_q, vinv_q, il_q, armed;
  logic [TW-1:0]   hb [7];
  logic [TW-1:0]   vb [7];

  for (genvar k = 0; k < 7; k++) begin : g_bnd
    assign hb[k] = upto(hl_q, k);
    assign vb[k] = upto(vl_q, k);
  end

  logic [TW-1:0] h_tot, v_tot, half;
  logic          h_end, v_end, f_end;
  assign h_tot = hb[6];
  assign v_tot = vb[6];
  assign half  = h_tot >> 1;
  assign h_end = (h_tot == '0) || (h_pos == h_tot - TW'(1));
  assign v_end = (v_tot == '0) || (v_pos == v_tot - TW'(1));
  assign f_end = h_end && v_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hl_q   <= '0;
      vl_q   <= '0;
      hinv_q <= 1'b0;
      vinv_q <= 1'b0;
      il_q   <= 1'b0;
      armed  <= 1'b1;
      h_pos  <= '0;
      v_pos  <= '0;
      field  <= 1'b0;
    end else if (pix_en) begin
      if (armed || f_end) begin
        hl_q   <= h_lens;
        vl_q   <= v_lens;
        hinv_q <= h_inv;
        vinv_q <= v_inv;
        il_q   <= ilace;
      end
      if (armed) begin
        armed <= 1'b0;
      end else begin
        h_pos <= h_end ? '0 : h_pos + TW'(1);
        if (h_end) v_pos <= v_end ? '0 : v_pos + TW'(1);
        if (f_end) field <= il_q ? ~field : 1'b0;
      end
    end
  end

  logic h_sy, h_dp, h_bd, v_sy_e, v_sy_o, v_dp, v_bd;
  assign h_sy = h_pos < hb[1];
  assign h_dp = (h_pos >= hb[3]) && (h_pos < hb[4]);
  assign h_bd = (h_pos >= hb[2]) && (h_pos < hb[5]);
  assign v_dp = (v_pos >= vb[3]) && (v_pos < vb[4]);
  assign v_bd = (v_pos >= vb[2]) && (v_pos < vb[5]);
  assign v_sy_e = v_pos < vb[1];
  assign v_sy_o = (vb[1] != '0) &&
                  (((v_pos == '0) && (h_pos >= half)) ||
                   ((v_pos != '0) && (v_pos < vb[1])) ||
                   ((v_pos == vb[1]) && (h_pos < half)));

  assign hsync   = h_sy ^ hinv_q;
  assign vsync   = (field ? v_sy_o : v_sy_e) ^ vinv_q;
  assign disp_en = h_dp && v_dp;
  assign bord_en = h_bd && v_bd && !disp_en;
endmodule

// File: rtl/video_timing_gen_chk.sv
module video_timing_gen_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          armed,
  input logic [CW+2:0] h_tot,
  input logic [CW+2:0] v_tot,
  input logic [CW+2:0] h_pos,
  input logic [CW+2:0] v_pos,
  input logic          field,
  input logic          disp_en,
  input logic          bord_en
);
  a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_en && bord_en));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(h_pos) && $stable(v_pos) && $stable(field));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !armed && (h_pos + 1'b1 < h_tot)) |=> h_pos == $past(h_pos) + 1'b1);

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !armed && h_tot != '0 && h_pos == h_tot - 1'b1) |=> h_pos == '0);

  a_r9_field_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) |-> (h_pos == '0 && v_pos == '0));

  a_r4_inside: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (h_pos < h_tot && v_pos < v_tot));
endmodule

bind video_timing_gen video_timing_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .armed(armed),
  .h_tot(h_tot), .v_tot(v_tot), .h_pos(h_pos), .v_pos(v_pos),
  .field(field), .disp_en(disp_en), .bord_en(bord_en)
);

// File: tb/video_timing_gen_tb.sv
`timescale 1ns/1ps
module video_timing_gen_tb;
  localparam int CW = 12;
  // cfg: [50]=ilace [49]=v_inv [48]=h_inv, v nibble k at 24+4k, h nibble k at 4k
  localparam logic [50:0] CFG [4] = '{
    {3'b000, 24'h113111, 24'h214112},
    {3'b001, 24'h102102, 24'h103021},
    {3'b110, 24'h112011, 24'h112113},
    {3'b100, 24'h112110, 24'h023201}
  };

  logic clk = 0, rst_n = 0, pix_en = 0;
  logic [6*CW-1:0] h_lens = '0, v_lens = '0;
  logic h_inv = 0, v_inv = 0, ilace = 0;
  logic hsync, vsync, disp_en, bord_en, field;
  logic [CW+2:0] h_pos, v_pos;

  always #5 clk = ~clk;

  video_timing_gen #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .h_lens(h_lens), .v_lens(v_lens),
    .h_inv(h_inv), .v_inv(v_inv), .ilace(ilace), .hsync(hsync), .vsync(vsync),
    .disp_en(disp_en), .bord_en(bord_en), .h_pos(h_pos), .v_pos(v_pos), .field(field)
  );

  int errors = 0, checks = 0;
  logic [50:0] cur, pend;
  int eh, ev;
  logic ef, loaded;
  string ph;

  function automatic int ln(input logic [50:0] c, input int base, input int k);
    return int'(c[base + 4*k +: 4]);
  endfunction
  function automatic int bnd(input logic [50:0] c, input int base, input int n);
    int s = 0;
    for (int k = 0; k < n; k++) s += ln(c, base, k);
    return s;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s%s: actual=%0d expected=%0d (h=%0d v=%0d)", ph, tag, act, exp, eh, ev);
    end
  endtask

  task automatic drive(input logic [50:0] c);
    for (int k = 0; k < 6; k++) begin
      h_lens[k*CW +: CW] = CW'(ln(c, 0, k));
      v_lens[k*CW +: CW] = CW'(ln(c, 24, k));
    end
    {ilace, v_inv, h_inv} = c[50:48];
    pend = c;
  endtask

  task automatic compare_all();
    int ht, hs, hd0, hd1, hb0, hb1, vs, vd0, vd1, vb0, vb1, half;
    logic esy, evs, hd, vd, hbd, vbd;
    ht = bnd(cur, 0, 6); half = ht / 2;
    hs = bnd(cur, 0, 1); hb0 = bnd(cur, 0, 2); hd0 = bnd(cur, 0, 3);
    hd1 = bnd(cur, 0, 4); hb1 = bnd(cur, 0, 5);
    vs = bnd(cur, 24, 1); vb0 = bnd(cur, 24, 2); vd0 = bnd(cur, 24, 3);
    vd1 = bnd(cur, 24, 4); vb1 = bnd(cur, 24, 5);
    esy = eh < hs;
    if (!ef) evs = ev < vs;
    else evs = (vs != 0) && ((ev == 0 && eh >= half) || (ev > 0 && ev < vs) ||
                             (ev == vs && eh < half));
    hd = eh >= hd0 && eh < hd1; vd = ev >= vd0 && ev < vd1;
    hbd = eh >= hb0 && eh < hb1; vbd = ev >= vb0 && ev < vb1;
    chk("R1/R6 hsync", int'(hsync), int'(esy ^ cur[48]));
    chk("R2/R6/R10 vsync", int'(vsync), int'(evs ^ cur[49]));
    chk("R4 disp_en", int'(disp_en), int'(hd && vd));
    chk("R5 bord_en", int'(bord_en), int'(hbd && vbd && !(hd && vd)));
    chk("R3 h_pos", int'(h_pos), eh);
    chk("R3 v_pos", int'(v_pos), ev);
    chk("R9 field", int'(field), int'(ef));
  endtask

  task automatic tick(input int gap);
    int ht, vt;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      compare_all();
    end
    pix_en = 1;
    @(negedge clk);
    pix_en = 0;
    if (!loaded) begin
      cur = pend; loaded = 1;
    end else begin
      ht = bnd(cur, 0, 6); vt = bnd(cur, 24, 6);
      if (ht == 0 || eh == ht - 1) begin
        eh = 0;
        if (vt == 0 || ev == vt - 1) begin
          ev = 0; ef = cur[50] ? ~ef : 1'b0; cur = pend;
        end else ev++;
      end else eh++;
    end
    compare_all();
  endtask

  task automatic do_reset(input logic [50:0] c);
    rst_n = 0; pix_en = 0;
    drive(c);
    cur = '0; eh = 0; ev = 0; ef = 0; loaded = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ph = "R12 ";
    chk("reset hsync", int'(hsync), 0);
    chk("reset vsync", int'(vsync), 0);
    chk("reset disp_en", int'(disp_en), 0);
    chk("reset bord_en", int'(bord_en), 0);
    chk("reset h_pos", int'(h_pos), 0);
    chk("reset v_pos", int'(v_pos), 0);
    chk("reset field", int'(field), 0);
    tick(0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 4; i++) begin
      do_reset(CFG[i]);
      ph = (i == 1 || i == 3) ? "R7 " : "";
      n = 3 * bnd(CFG[i], 0, 6) * bnd(CFG[i], 24, 6);
      for (int t = 0; t < n; t++) tick((t % 7 == 3) ? 2 : 0);
    end

    do_reset(CFG[0]);
    ph = "R8 ";
    for (int t = 0; t < 30; t++) tick(0);
    drive(CFG[2]);
    for (int t = 0; t < 3 * 117; t++) tick(0);

    ph = "R11 ";
    for (int t = 0; t < 5; t++) tick(4);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule